// File: doc/BRIEF.md
# Data Watchpoint Bank

This block holds a configurable number of data watchpoints and checks each load or store seen by the core against all of them. Every watchpoint has an address register and a control register, both written through a small configuration port. The control word selects which access directions are watched, which privilege levels and security states may fire, whether a linked breakpoint must also pass, and how the watched byte range is formed. The range is either an aligned power-of-two block or a short run of bytes picked by an 8-bit byte-select field.

Encodings that would otherwise be undefined are resolved in one fixed way. A nonzero size field overrides byte-select. Only the lowest contiguous run of byte-select ones is used. An address with bit 2 set narrows byte-select to its low four bits. The result of each access appears one clock later as a hit flag with the index of the lowest-numbered watchpoint that hit, the write flag and the access address, ready for the exception syndrome.

Top module: `wp_bank`

## Requirements
- R1: After reset every register is zero and no access hits. An entry whose enable bit (control bit 0) is clear never hits. Address register bits [1:0] are stored as zero whatever is written.
- R2: The direction field in control bits [4:3] gates the access type. Bit 3 allows reads (acc_write=0) and bit 4 allows writes (acc_write=1), so 00 never hits.
- R3: The size field in control bits [28:24] selects block mode. Values 1 and 2 never hit. A value m of 3 or more watches the aligned 2^m-byte block holding the address register, ignores its low m bits and ignores byte-select.
- R4: With size 0, byte-select is control bits [12:5]; when address bit 2 is set only its bits [3:0] count. A zero select never hits. Otherwise the watched bytes start at the lowest set bit, counted from the address with bits [1:0] cleared, and run over the following contiguous ones. Later ones are ignored.
- R5: An access of acc_len bytes (1 to MAX_ACC) starting at acc_addr hits when any of its bytes lies in the watched range.
- R6: The effective level is 0 when acc_unpriv is set and core_level otherwise. Level 0 needs control bit 1, level 1 needs control bit 2, and levels 2 and 3 need control bit 13.
- R7: The security field in control bits [15:14] is checked against core_secure. 01 fires only when it is 0, 10 fires only when it is 1, and 00 or 11 fire in both states.
- R8: No access hits unless both mon_dbg_en and dbg_exc_en are high.
- R9: When control bit 20 is set, a hit also needs bp_pass[n], where n is control bits [19:16]. Values of n at or above NUM_BP never pass.
- R10: One cycle after acc_valid, res_valid is high, res_addr is the access address, and res_hit reports whether any entry hit. On a hit, res_idx is the lowest hitting entry and res_wnr is the access's write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 writes the address register, 1 writes the control register |
| cfg_idx | input | IDX_W | Entry written |
| cfg_wdata | input | ADDR_W | Write data |
| mon_dbg_en | input | 1 | Global watchpoint enable |
| dbg_exc_en | input | 1 | Debug exceptions currently allowed |
| core_level | input | 2 | Current privilege level of the core |
| core_secure | input | 1 | Core is in secure state |
| bp_pass | input | NUM_BP | Per-breakpoint link result |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | ADDR_W | First byte address of the access |
| acc_len | input | LEN_W | Access length in bytes |
| acc_write | input | 1 | Access is a store |
| acc_unpriv | input | 1 | Unprivileged load/store form |
| res_valid | output | 1 | Result for last cycle's access |
| res_hit | output | 1 | Some watchpoint hit |
| res_idx | output | IDX_W | Lowest hitting entry |
| res_wnr | output | 1 | Write-not-read of the hitting access |
| res_addr | output | ADDR_W | Address of the access |

## Verification
Directed accesses straddle both edges of byte-select runs and power-of-two blocks. This separates the any-byte overlap rule from a start-address-only compare, and shows the first-run rule apart from a plain bit lookup. Legacy half-width select, reserved size values and out-of-range link numbers each get an access that would hit under the wrong resolution. Seeded random configurations and accesses in a small address window are checked against a byte-by-byte model, which exercises the combinations of direction, level, security and link checks together with the lowest-index selection when several entries overlap.

// File: rtl/wp_pkg.sv
package wp_pkg;

   // Control register layout, MSB first.
   typedef struct packed {
      logic [2:0] rsv_hi;
      logic [4:0] size_log2;
      logic [2:0] rsv_mid;
      logic       linked;
      logic [3:0] link_num;
      logic [1:0] sec_sel;
      logic       high_lvl;
      logic [7:0] byte_sel;
      logic [1:0] dir;
      logic [1:0] lvl_ok;
      logic       en;
   } wp_ctl_t;

   localparam int CTL_W      = 32;
   localparam int LINK_SPACE = 16;
   localparam int MIN_SIZE   = 3;

endpackage

// File: rtl/wp_range_decode.sv
module wp_range_decode #(
   parameter int ADDR_W      = 32,
   parameter bit LEGACY_WORD = 1'b1
) (
   input  logic [ADDR_W-1:0] wvr,
   input  logic [4:0]        size_log2,
   input  logic [7:0]        byte_sel,
   output logic              valid,
   output logic [ADDR_W-1:0] base,
   output logic [ADDR_W:0]   len
);
   import wp_pkg::*;

   logic [7:0] sel;
   logic [3:0] first;
   logic [3:0] run;
   logic       seen;
   logic       stop;

   generate
      if (LEGACY_WORD) begin : g_legacy
         assign sel = wvr[2] ? {4'h0, byte_sel[3:0]} : byte_sel;
      end else begin : g_plain
         assign sel = byte_sel;
      end
   endgenerate

   always_comb begin
      first = 4'd0;
      seen  = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (!seen && sel[i]) begin
            first = 4'(i);
            seen  = 1'b1;
         end
      end
      run  = 4'd0;
      stop = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (4'(i) >= first) begin
            if (!stop && sel[i]) run = run + 4'd1;
            else                 stop = 1'b1;
         end
      end
   end

   always_comb begin
      if (size_log2 != 5'd0) begin
         valid = (size_log2 >= 5'(MIN_SIZE));
         base  = wvr & ({ADDR_W{1'b1}} << size_log2);
         len   = (ADDR_W+1)'(1) << size_log2;
      end else begin
         valid = (sel != 8'h00);
         base  = {wvr[ADDR_W-1:2], 2'b00} + ADDR_W'(first);
         len   = (ADDR_W+1)'(run);
      end
   end

endmodule

// File: rtl/wp_entry.sv
module wp_entry #(
   parameter int ADDR_W = 32,
   parameter int NUM_BP = 6,
   parameter int LEN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_val,
   input  logic              wr_ctl,
   input  logic [ADDR_W-1:0] wdata,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [LEN_W-1:0]  acc_len,
   input  logic              acc_write,
   input  logic [1:0]        eff_level,
   input  logic              core_secure,
   input  logic [NUM_BP-1:0] bp_pass,
   output logic              match
);
   import wp_pkg::*;

   localparam int XW = ADDR_W + 2;

   logic [ADDR_W-1:0] wvr;
   logic [CTL_W-1:0]  wcr;
   wp_ctl_t           f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wvr <= '0;
         wcr <= '0;
      end else begin
         if (wr_val) wvr <= {wdata[ADDR_W-1:2], 2'b00};
         if (wr_ctl) wcr <= wdata[CTL_W-1:0];
      end
   end

   assign f = wp_ctl_t'(wcr);

   logic              dec_ok;
   logic [ADDR_W-1:0] rng_base;
   logic [ADDR_W:0]   rng_len;

   wp_range_decode #(.ADDR_W(ADDR_W), .LEGACY_WORD(1'b1)) u_dec (
      .wvr       (wvr),
      .size_log2 (f.size_log2),
      .byte_sel  (f.byte_sel),
      .valid     (dec_ok),
      .base      (rng_base),
      .len       (rng_len)
   );

   logic [LEN_W-1:0] len_eff;
   logic [XW-1:0]    a_lo, a_hi, r_lo, r_end;
   logic             overlap, dir_ok, lvl_ok, sec_ok, link_ok;
   logic [LINK_SPACE-1:0] bp_ext;

   assign len_eff = (acc_len == '0) ? LEN_W'(1) : acc_len;
   assign a_lo    = XW'(acc_addr);
   assign a_hi    = a_lo + XW'(len_eff) - XW'(1);
   assign r_lo    = XW'(rng_base);
   assign r_end   = r_lo + XW'(rng_len);
   assign overlap = (a_lo < r_end) && (a_hi >= r_lo);

   assign dir_ok  = acc_write ? f.dir[1] : f.dir[0];

   always_comb begin
      case (eff_level)
         2'd0:    lvl_ok = f.lvl_ok[0];
         2'd1:    lvl_ok = f.lvl_ok[1];
         default: lvl_ok = f.high_lvl;
      endcase
   end

   always_comb begin
      case (f.sec_sel)
         2'b01:   sec_ok = !core_secure;
         2'b10:   sec_ok = core_secure;
         default: sec_ok = 1'b1;
      endcase
   end

   assign bp_ext  = LINK_SPACE'(bp_pass);
   assign link_ok = !f.linked || bp_ext[f.link_num];

   assign match = f.en && dec_ok && dir_ok && lvl_ok && sec_ok && link_ok && overlap;

endmodule

// File: rtl/wp_prio_pick.sv
module wp_prio_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/wp_bank.sv
module wp_bank #(
   parameter int NUM_WP  = 4,
   parameter int NUM_BP  = 6,
   parameter int ADDR_W  = 32,
   parameter int MAX_ACC = 8,
   localparam int IDX_W  = (NUM_WP > 1) ? $clog2(NUM_WP) : 1,
   localparam int LEN_W  = $clog2(MAX_ACC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              mon_dbg_en,
   input  logic              dbg_exc_en,
   input  logic [1:0]        core_level,
   input  logic              core_secure,
   input  logic [NUM_BP-1:0] bp_pass,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [LEN_W-1:0]  acc_len,
   input  logic              acc_write,
   input  logic              acc_unpriv,
   output logic              res_valid,
   output logic              res_hit,
   output logic [IDX_W-1:0]  res_idx,
   output logic              res_wnr,
   output logic [ADDR_W-1:0] res_addr
);
   import wp_pkg::*;

   generate
      if (ADDR_W < CTL_W) begin : g_bad_addr_w
         $error("wp_bank: ADDR_W must be at least the control width");
      end
      if (NUM_BP < 1 || NUM_BP > LINK_SPACE) begin : g_bad_num_bp
         $error("wp_bank: NUM_BP out of range");
      end
      if (NUM_WP < 1) begin : g_bad_num_wp
         $error("wp_bank: NUM_WP must be positive");
      end
      if (MAX_ACC < 1) begin : g_bad_max_acc
         $error("wp_bank: MAX_ACC must be positive");
      end
   endgenerate

   logic [1:0]        eff_level;
   logic [NUM_WP-1:0] hits;
   logic              any_hit;
   logic [IDX_W-1:0]  first_idx;

   assign eff_level = acc_unpriv ? 2'd0 : core_level;

   generate
      for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
         logic sel_me;
         assign sel_me = cfg_we && (cfg_idx == IDX_W'(g));
         wp_entry #(.ADDR_W(ADDR_W), .NUM_BP(NUM_BP), .LEN_W(LEN_W)) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_val      (sel_me && !cfg_sel),
            .wr_ctl      (sel_me && cfg_sel),
            .wdata       (cfg_wdata),
            .acc_addr    (acc_addr),
            .acc_len     (acc_len),
            .acc_write   (acc_write),
            .eff_level   (eff_level),
            .core_secure (core_secure),
            .bp_pass     (bp_pass),
            .match       (hits[g])
         );
      end
   endgenerate

   wp_prio_pick #(.N(NUM_WP), .IDX_W(IDX_W)) u_pick (
      .req (hits),
      .any (any_hit),
      .idx (first_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_idx   <= '0;
         res_wnr   <= 1'b0;
         res_addr  <= '0;
      end else begin
         res_valid <= acc_valid;
         res_hit   <= acc_valid && mon_dbg_en && dbg_exc_en && any_hit;
         if (acc_valid) begin
            res_idx  <= any_hit ? first_idx : '0;
            res_wnr  <= acc_write;
            res_addr <= acc_addr;
         end
      end
   end

endmodule

// File: rtl/wp_bank_chk.sv
module wp_bank_chk #(
   parameter int IDX_W  = 2,
   parameter int ADDR_W = 32,
   parameter int NUM_WP = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_write,
   input logic              mon_dbg_en,
   input logic              dbg_exc_en,
   input logic              res_valid,
   input logic              res_hit,
   input logic [IDX_W-1:0]  res_idx,
   input logic              res_wnr,
   input logic [ADDR_W-1:0] res_addr
);
   AST_GATED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !(mon_dbg_en && dbg_exc_en)) |=> !res_hit); // R8
   AST_HIT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> res_valid); // R10
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> res_valid); // R10
   AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!res_valid && !res_hit)); // R10
   AST_ADDR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> (res_addr == $past(acc_addr))); // R10
   AST_WNR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> (res_wnr == $past(acc_write))); // R10
   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> (int'(res_idx) < NUM_WP)); // R10
endmodule

bind wp_bank wp_bank_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .NUM_WP(NUM_WP)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_valid  (acc_valid),
   .acc_addr   (acc_addr),
   .acc_write  (acc_write),
   .mon_dbg_en (mon_dbg_en),
   .dbg_exc_en (dbg_exc_en),
   .res_valid  (res_valid),
   .res_hit    (res_hit),
   .res_idx    (res_idx),
   .res_wnr    (res_wnr),
   .res_addr   (res_addr)
);

// File: tb/sim_wp_bank.sv
module sim_wp_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NWP = 4;
   localparam int NBP = 6;
   localparam int AW  = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cfg_we = 1'b0;
   logic           cfg_sel = 1'b0;
   logic [1:0]     cfg_idx = '0;
   logic [AW-1:0]  cfg_wdata = '0;
   logic           mon_dbg_en = 1'b1;
   logic           dbg_exc_en = 1'b1;
   logic [1:0]     core_level = 2'd1;
   logic           core_secure = 1'b0;
   logic [NBP-1:0] bp_pass = '0;
   logic           acc_valid = 1'b0;
   logic [AW-1:0]  acc_addr = '0;
   logic [3:0]     acc_len = 4'd1;
   logic           acc_write = 1'b0;
   logic           acc_unpriv = 1'b0;
   logic           res_valid, res_hit, res_wnr;
   logic [1:0]     res_idx;
   logic [AW-1:0]  res_addr;

   int n_tests = 0;
   int n_fail  = 0;
   logic [31:0] sh_wvr [NWP];
   logic [31:0] sh_wcr [NWP];

   always #(CLK_PERIOD/2) clk = ~clk;

   wp_bank #(.NUM_WP(NWP), .NUM_BP(NBP), .ADDR_W(AW), .MAX_ACC(8)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .mon_dbg_en(mon_dbg_en),
      .dbg_exc_en(dbg_exc_en), .core_level(core_level), .core_secure(core_secure),
      .bp_pass(bp_pass), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_len(acc_len), .acc_write(acc_write), .acc_unpriv(acc_unpriv),
      .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
      .res_wnr(res_wnr), .res_addr(res_addr)
   );

   function automatic logic [31:0] mk_ctl(bit en, bit [1:0] pac, bit [1:0] lsc,
      bit [7:0] bas, bit hmc, bit [1:0] ssc, bit [3:0] lbn, bit lk, bit [4:0] msk);
      return {3'b000, msk, 3'b000, lk, lbn, ssc, hmc, bas, lsc, pac, en};
   endfunction

   // Is byte b inside entry i's watched range (R3, R4)?
   function automatic bit byte_in(int i, logic [31:0] b);
      logic [31:0] w = sh_wvr[i];
      logic [31:0] c = sh_wcr[i];
      logic [4:0]  m = c[28:24];
      logic [7:0]  sel;
      int pos, first, k;
      bit inrun;
      if (m != 0) begin
         if (m < 3) return 0;
         return (b >> m) == (w >> m);
      end
      if (w[2]) begin
         if (b[31:2] != w[31:2]) return 0;
         sel = {4'h0, c[8:5]};
         pos = int'(b[1:0]);
      end else begin
         if (b[31:3] != w[31:3]) return 0;
         sel = c[12:5];
         pos = int'(b[2:0]);
      end
      if (sel == 0) return 0;
      first = 0;
      while (!sel[first]) first++;
      inrun = 1;
      for (k = first; k < 8; k++) begin
         if (!sel[k]) inrun = 0;
         if (k == pos) return inrun;
      end
      return 0;
   endfunction

   function automatic bit entry_hit(int i, logic [31:0] a, int len, bit wr, bit up);
      logic [31:0] c = sh_wcr[i];
      int lvl = up ? 0 : int'(core_level);
      bit ok;
      logic [15:0] bpx = 16'(bp_pass);
      if (!c[0]) return 0;
      if (wr ? !c[4] : !c[3]) return 0;
      ok = (lvl == 0) ? c[1] : (lvl == 1) ? c[2] : c[13];
      if (!ok) return 0;
      if (c[15:14] == 2'b01 && core_secure) return 0;
      if (c[15:14] == 2'b10 && !core_secure) return 0;
      if (c[20] && !bpx[c[19:16]]) return 0;
      for (int k = 0; k < len; k++)
         if (byte_in(i, a + 32'(k))) return 1;
      return 0;
   endfunction

   task automatic wr_reg(int idx, bit sel, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 2'(idx); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel) sh_wcr[idx] = d;
      else     sh_wvr[idx] = d & ~32'h3;
   endtask

   task automatic acc(logic [31:0] a, int len, bit wr, bit up, bit eh, int ei, string tag);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_len = 4'(len);
      acc_write = wr; acc_unpriv = up;
      @(negedge clk);
      acc_valid = 1'b0;
      n_tests++;
      if (res_valid !== 1'b1 || res_hit !== eh || res_addr !== a ||
          (eh && (int'(res_idx) != ei || res_wnr !== wr))) begin
         n_fail++;
         $display("FAIL %s: valid=%0b hit=%0b idx=%0d wnr=%0b addr=%h expected valid=1 hit=%0b idx=%0d wnr=%0b addr=%h",
                  tag, res_valid, res_hit, res_idx, res_wnr, res_addr, eh, ei, wr, a);
      end
   endtask

   task automatic acc_model(logic [31:0] a, int len, bit wr, bit up, string tag);
      bit eh = 0;
      int ei = 0;
      if (mon_dbg_en && dbg_exc_en) begin
         for (int i = NWP - 1; i >= 0; i--)
            if (entry_hit(i, a, len, wr, up)) begin eh = 1; ei = i; end
      end
      acc(a, len, wr, up, eh, ei, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] c0;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NWP; i++) begin sh_wvr[i] = 0; sh_wcr[i] = 0; end
      repeat (3) @(negedge clk);
      n_tests++;
      if (res_valid !== 1'b0 || res_hit !== 1'b0 || res_addr !== '0) begin
         n_fail++;
         $display("FAIL R1 reset: valid=%0b hit=%0b addr=%h expected 0 0 0", res_valid, res_hit, res_addr);
      end
      rst_n = 1'b1;
      acc(32'h0, 1, 0, 0, 0, 0, "R1 reset entries disabled");

      // Byte-select and overlap
      c0 = mk_ctl(1, 2'b11, 2'b11, 8'h0F, 0, 2'b00, 4'd0, 0, 5'd0);
      wr_reg(0, 0, 32'h1000); wr_reg(0, 1, c0);
      acc(32'h1000, 1, 0, 0, 1, 0, "R4 first byte");
      acc(32'h1004, 1, 0, 0, 0, 0, "R4 past run");
      acc(32'h0FFE, 4, 0, 0, 1, 0, "R5 overlap low edge");
      acc(32'h0FFC, 4, 0, 0, 0, 0, "R5 just below");
      acc(32'h1003, 8, 1, 0, 1, 0, "R5 overlap write");
      wr_reg(0, 1, c0 & ~32'h1);
      acc(32'h1000, 1, 0, 0, 0, 0, "R1 enable clear");

      // Direction field
      wr_reg(0, 1, mk_ctl(1, 2'b11, 2'b01, 8'h0F, 0, 0, 0, 0, 0));
      acc(32'h1000, 1, 1, 0, 0, 0, "R2 read-only blocks write");
      acc(32'h1000, 1, 0, 0, 1, 0, "R2 read-only read");
      wr_reg(0, 1, mk_ctl(1, 2'b11, 2'b10, 8'h0F, 0, 0, 0, 0, 0));
      acc(32'h1000, 1, 0, 0, 0, 0, "R2 write-only blocks read");
      acc(32'h1000, 1, 1, 0, 1, 0, "R2 write-only write");
      wr_reg(0, 1, mk_ctl(1, 2'b11, 2'b00, 8'h0F, 0, 0, 0, 0, 0));
      acc(32'h1000, 1, 0, 0, 0, 0, "R2 dir 00");

      // First run only, legacy word mode
      wr_reg(0, 1, mk_ctl(1, 2'b11, 2'b11, 8'h63, 0, 0, 0, 0, 0));
      acc(32'h1005, 1, 0, 0, 0, 0, "R4 later ones ignored");
      acc(32'h1001, 1, 0, 0, 1, 0, "R4 inside first run");
      wr_reg(0, 0, 32'h1004);
      wr_reg(0, 1, mk_ctl(1, 2'b11, 2'b11, 8'hF0, 0, 0, 0, 0, 0));
      acc(32'h1004, 1, 0, 0, 0, 0, "R4 half select zero");
      wr_reg(0, 1, mk_ctl(1, 2'b11, 2'b11, 8'hFC, 0, 0, 0, 0, 0));
      acc(32'h1006, 1, 0, 0, 1, 0, "R4 half select hit");
      acc(32'h1005, 1, 0, 0, 0, 0, "R4 half select below run");
      acc(32'h1000, 1, 0, 0, 0, 0, "R4 half select other word");
      wr_reg(0, 0, 32'h1003);
      wr_reg(0, 1, mk_ctl(1, 2'b11, 2'b11, 8'h01, 0, 0, 0, 0, 0));
      acc(32'h1000, 1, 0, 0, 1, 0, "R1 low address bits cleared");
      acc(32'h1001, 1, 0, 0, 0, 0, "R1 low address bits cleared miss");

      // Block mode
      wr_reg(0, 0, 32'h2345);
      wr_reg(0, 1, mk_ctl(1, 2'b11, 2'b11, 8'h00, 0, 0, 0, 0, 5'd8));
      acc(32'h23FF, 1, 0, 0, 1, 0, "R3 block top");
      acc(32'h2300, 1, 0, 0, 1, 0, "R3 block bottom");
      acc(32'h2400, 1, 0, 0, 0, 0, "R3 above block");
      acc(32'h22FF, 1, 0, 0, 0, 0, "R3 below block");
      wr_reg(0, 1, mk_ctl(1, 2'b11, 2'b11, 8'hFF, 0, 0, 0, 0, 5'd2));
      acc(32'h2344, 1, 0, 0, 0, 0, "R3 size 2 reserved");
      wr_reg(0, 1, mk_ctl(1, 2'b11, 2'b11, 8'hFF, 0, 0, 0, 0, 5'd1));
      acc(32'h2344, 1, 0, 0, 0, 0, "R3 size 1 reserved");

      // Privilege
      wr_reg(0, 0, 32'h1000);
      wr_reg(0, 1, mk_ctl(1, 2'b01, 2'b11, 8'h0F, 0, 0, 0, 0, 0));
      acc(32'h1000, 1, 0, 0, 0, 0, "R6 level1 not allowed");
      acc(32'h1000, 1, 0, 1, 1, 0, "R6 unpriv counts as level0");
      core_level = 2'd0;
      acc(32'h1000, 1, 0, 0, 1, 0, "R6 level0");
      core_level = 2'd2;
      acc(32'h1000, 1, 0, 0, 0, 0, "R6 level2 without high bit");
      wr_reg(0, 1, mk_ctl(1, 2'b01, 2'b11, 8'h0F, 1, 0, 0, 0, 0));
      acc(32'h1000, 1, 0, 0, 1, 0, "R6 level2 with high bit");
      core_level = 2'd3;
      acc(32'h1000, 1, 0, 0, 1, 0, "R6 level3 with high bit");
      core_level = 2'd1;

      // Security
      wr_reg(0, 1, mk_ctl(1, 2'b11, 2'b11, 8'h0F, 0, 2'b01, 0, 0, 0));
      core_secure = 1'b1;
      acc(32'h1000, 1, 0, 0, 0, 0, "R7 nonsecure-only in secure");
      core_secure = 1'b0;
      acc(32'h1000, 1, 0, 0, 1, 0, "R7 nonsecure-only in nonsecure");
      wr_reg(0, 1, mk_ctl(1, 2'b11, 2'b11, 8'h0F, 0, 2'b10, 0, 0, 0));
      acc(32'h1000, 1, 0, 0, 0, 0, "R7 secure-only in nonsecure");
      core_secure = 1'b1;
      acc(32'h1000, 1, 0, 0, 1, 0, "R7 secure-only in secure");
      core_secure = 1'b0;

      // Global gating
      wr_reg(0, 1, c0);
      mon_dbg_en = 1'b0;
      acc(32'h1000, 1, 0, 0, 0, 0, "R8 monitor enable off");
      mon_dbg_en = 1'b1; dbg_exc_en = 1'b0;
      acc(32'h1000, 1, 0, 0, 0, 0, "R8 debug exceptions off");
      dbg_exc_en = 1'b1;

      // Link
      wr_reg(0, 1, mk_ctl(1, 2'b11, 2'b11, 8'h0F, 0, 0, 4'd2, 1, 0));
      bp_pass = 6'b000000;
      acc(32'h1000, 1, 0, 0, 0, 0, "R9 link fails");
      bp_pass = 6'b000100;
      acc(32'h1000, 1, 0, 0, 1, 0, "R9 link passes");
      bp_pass = 6'b111111;
      wr_reg(0, 1, mk_ctl(1, 2'b11, 2'b11, 8'h0F, 0, 0, 4'd9, 1, 0));
      acc(32'h1000, 1, 0, 0, 0, 0, "R9 link number out of range");
      wr_reg(0, 1, mk_ctl(1, 2'b11, 2'b11, 8'h0F, 0, 0, 4'd5, 1, 0));
      acc(32'h1000, 1, 0, 0, 1, 0, "R9 highest link number");
      bp_pass = '0;

      // Priority
      wr_reg(0, 1, 32'h0);
      wr_reg(1, 0, 32'h3000); wr_reg(1, 1, mk_ctl(1, 2'b11, 2'b11, 8'hFF, 0, 0, 0, 0, 0));
      wr_reg(3, 0, 32'h3000); wr_reg(3, 1, mk_ctl(1, 2'b11, 2'b11, 8'hFF, 0, 0, 0, 0, 0));
      acc(32'h3002, 2, 1, 0, 1, 1, "R10 lowest index wins");
      wr_reg(1, 1, 32'h0);
      acc(32'h3002, 2, 0, 0, 1, 3, "R10 only entry3");

      // Seeded random
      for (int it = 0; it < 400; it++) begin
         if ($urandom % 2 == 0) begin
            int e = int'($urandom % NWP);
            logic [4:0] m = ($urandom % 4 == 0) ? 5'($urandom % 10) : 5'd0;
            wr_reg(e, 0, 32'h1000 + ($urandom % 32'h80));
            wr_reg(e, 1, mk_ctl(($urandom % 8) != 0, 2'($urandom), 2'($urandom),
                                8'($urandom), 1'($urandom), 2'($urandom),
                                4'($urandom % 8), ($urandom % 4) == 0, m));
         end
         core_level  = 2'($urandom);
         core_secure = 1'($urandom);
         bp_pass     = 6'($urandom);
         mon_dbg_en  = ($urandom % 10) != 0;
         dbg_exc_en  = ($urandom % 10) != 0;
         acc_model(32'h0FF0 + ($urandom % 32'hA0), 1 + int'($urandom % 8),
                   1'($urandom), 1'($urandom), "R10 random vs model");
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule